// File: doc/BRIEF.md
# Single-Cycle 32-bit Integer Core

This block is a small 32-bit processor core that completes one instruction in every clock cycle. Each cycle it presents its program counter as an instruction address, decodes the returned word, reads two source registers, and runs them through an ALU. On the closing clock edge it commits the result to a register, to data memory or to the program counter. It supports eight instructions: four register-register operations (add, subtract, and, or), a signed set-on-less-than, a word load, a word store, and a branch taken when two registers are equal.

The core has no memories of its own. Instruction fetch and data reads are combinational: the core drives an address and expects the data in the same cycle. Data writes take effect on the clock edge while the store strobe is high. Instruction words use a 6-bit opcode in bits 31:26, source fields in bits 25:21 and 20:16, and either a destination in 15:11 with a function code in 5:0, or a 16-bit signed immediate in 15:0.

Top module: `ucore_top`

## Requirements
- R1: While `rst` is high at a rising clock edge, the program counter is cleared, so `instrAddr` reads 0 in the cycle after reset.
- R2: Every instruction other than a taken branch advances `instrAddr` by exactly 4.
- R3: Opcode 0x00 with function code 0x20 writes rs + rt to register rd, and with 0x22 writes rs - rt, both wrapping modulo 2^32.
- R4: Opcode 0x00 with function code 0x24 writes the bitwise AND of rs and rt to rd, and with 0x25 writes the bitwise OR.
- R5: Opcode 0x00 with function code 0x2A writes 1 to rd when rs is less than rt as two's-complement values, and 0 otherwise.
- R6: Opcode 0x23 drives `dataAddr` = rs + sign-extended imm16 and writes `dataRdata` into register rt.
- R7: Opcode 0x2B raises `dataWe`, drives `dataAddr` = rs + sign-extended imm16 and `dataWdata` = rt, and writes no register.
- R8: Opcode 0x04 sets the next address to PC + 4 + (sign-extended imm16 × 4) when rs equals rt, and to PC + 4 otherwise.
- R9: Register 0 always reads as zero, and any write aimed at it is dropped.
- R10: `dataWe` is high only during a store instruction.
- R11: An opcode outside {0x00, 0x23, 0x2B, 0x04}, or opcode 0x00 with a function code outside {0x20, 0x22, 0x24, 0x25, 0x2A}, writes no register and no memory and advances the PC by 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset of the program counter |
| instrAddr | output | 32 | Byte address of the current instruction |
| instrData | input | 32 | Instruction word returned for `instrAddr` in the same cycle |
| dataAddr | output | 32 | Byte address for a load or store |
| dataWdata | output | 32 | Store data |
| dataWe | output | 1 | Store strobe; memory writes on the clock edge while high |
| dataRdata | input | 32 | Load data returned for `dataAddr` in the same cycle |

## Verification
Two events can fall in the same cycle: the register read of an instruction and the register write-back of that same instruction, when a destination is also a source (for example add r3,r3,r3). The other case is a store followed at once by a load from the same word. The bench forces both with directed sequences, and random register fields recreate them often. The results are judged by storing the affected register and comparing the store data against a bench model. That model reads operands before it commits results and keeps its own copy of data memory.

// File: rtl/ucore_pkg.sv
`timescale 1ns/1ps
package ucore_pkg;

  localparam logic [5:0] OP_RTYPE = 6'h00;
  localparam logic [5:0] OP_LOAD  = 6'h23;
  localparam logic [5:0] OP_STORE = 6'h2B;
  localparam logic [5:0] OP_BREQ  = 6'h04;

  localparam logic [5:0] FN_ADD = 6'h20;
  localparam logic [5:0] FN_SUB = 6'h22;
  localparam logic [5:0] FN_AND = 6'h24;
  localparam logic [5:0] FN_OR  = 6'h25;
  localparam logic [5:0] FN_SLT = 6'h2A;

  typedef enum logic [2:0] {
    ALU_ADD = 3'd0,
    ALU_SUB = 3'd1,
    ALU_AND = 3'd2,
    ALU_OR  = 3'd3,
    ALU_SLT = 3'd4
  } aluOp_t;

  // strobes from control to datapath
  typedef struct packed {
    logic   regWrite;
    logic   regDstRd;
    logic   aluSrcImm;
    logic   memToReg;
    logic   memWrite;
    logic   branch;
    aluOp_t aluOp;
  } ctrl_t;

endpackage

// File: rtl/ucore_control.sv
`timescale 1ns/1ps
module ucore_control
  import ucore_pkg::*;
(
  input  logic [5:0] opcode,
  input  logic [5:0] funct,
  output ctrl_t      ctrl
);

  always_comb begin
    ctrl.regWrite  = 1'b0;
    ctrl.regDstRd  = 1'b0;
    ctrl.aluSrcImm = 1'b0;
    ctrl.memToReg  = 1'b0;
    ctrl.memWrite  = 1'b0;
    ctrl.branch    = 1'b0;
    ctrl.aluOp     = ALU_ADD;
    case (opcode)
      OP_RTYPE: begin
        ctrl.regDstRd = 1'b1;
        case (funct)
          FN_ADD: begin ctrl.regWrite = 1'b1; ctrl.aluOp = ALU_ADD; end
          FN_SUB: begin ctrl.regWrite = 1'b1; ctrl.aluOp = ALU_SUB; end
          FN_AND: begin ctrl.regWrite = 1'b1; ctrl.aluOp = ALU_AND; end
          FN_OR:  begin ctrl.regWrite = 1'b1; ctrl.aluOp = ALU_OR;  end
          FN_SLT: begin ctrl.regWrite = 1'b1; ctrl.aluOp = ALU_SLT; end
          default: ctrl.regWrite = 1'b0;
        endcase
      end
      OP_LOAD: begin
        ctrl.regWrite  = 1'b1;
        ctrl.aluSrcImm = 1'b1;
        ctrl.memToReg  = 1'b1;
      end
      OP_STORE: begin
        ctrl.aluSrcImm = 1'b1;
        ctrl.memWrite  = 1'b1;
      end
      OP_BREQ: begin
        ctrl.branch = 1'b1;
        ctrl.aluOp  = ALU_SUB;
      end
      default: ctrl.branch = 1'b0;
    endcase
  end

endmodule

// File: rtl/ucore_regfile.sv
`timescale 1ns/1ps
module ucore_regfile #(
  parameter int XLEN    = 32,
  parameter int REG_CNT = 32,
  localparam int REG_AW = $clog2(REG_CNT)
) (
  input  logic              clk,
  input  logic [REG_AW-1:0] rdAddrA,
  input  logic [REG_AW-1:0] rdAddrB,
  output logic [XLEN-1:0]   rdDataA,
  output logic [XLEN-1:0]   rdDataB,
  input  logic              wrEn,
  input  logic [REG_AW-1:0] wrAddr,
  input  logic [XLEN-1:0]   wrData
);

  logic [XLEN-1:0] regs [REG_CNT];

  // entry 0 is never written; reads of it are forced to zero
  always_ff @(posedge clk) begin
    if (wrEn && (wrAddr != '0)) begin
      regs[wrAddr] <= wrData;
    end
  end

  assign rdDataA = (rdAddrA == '0) ? '0 : regs[rdAddrA];
  assign rdDataB = (rdAddrB == '0) ? '0 : regs[rdAddrB];

endmodule

// File: rtl/ucore_alu.sv
`timescale 1ns/1ps
module ucore_alu
  import ucore_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0] opA,
  input  logic [XLEN-1:0] opB,
  input  aluOp_t          op,
  output logic [XLEN-1:0] result,
  output logic            isZero
);

  always_comb begin
    case (op)
      ALU_ADD: result = opA + opB;
      ALU_SUB: result = opA - opB;
      ALU_AND: result = opA & opB;
      ALU_OR:  result = opA | opB;
      ALU_SLT: result = {{(XLEN-1){1'b0}}, ($signed(opA) < $signed(opB))};
      default: result = '0;
    endcase
  end

  assign isZero = (result == '0);

endmodule

// File: rtl/ucore_datapath.sv
`timescale 1ns/1ps
module ucore_datapath
  import ucore_pkg::*;
#(
  parameter int          XLEN     = 32,
  parameter int          REG_CNT  = 32,
  parameter logic [31:0] RESET_PC = 32'h0
) (
  input  logic            clk,
  input  logic            rst,
  input  ctrl_t           ctrl,
  output logic [XLEN-1:0] instrAddr,
  input  logic [31:0]     instrData,
  output logic [XLEN-1:0] dataAddr,
  output logic [XLEN-1:0] dataWdata,
  output logic            dataWe,
  input  logic [XLEN-1:0] dataRdata
);

  localparam int REG_AW  = $clog2(REG_CNT);
  localparam int IMM_W   = 16;
  localparam int INSTR_B = 4;

  logic [XLEN-1:0]   pc, pcNext, pcSeq, pcBranch;
  logic [REG_AW-1:0] rsField, rtField, rdField, wrAddr;
  logic [IMM_W-1:0]  immField;
  logic [XLEN-1:0]   immExt, rsVal, rtVal, aluB, aluY, wbData;
  logic              aluZero;
  logic              unusedShamt;

  assign rsField     = instrData[21 +: REG_AW];
  assign rtField     = instrData[16 +: REG_AW];
  assign rdField     = instrData[11 +: REG_AW];
  assign immField    = instrData[IMM_W-1:0];
  assign unusedShamt = ^instrData[10:6];

  assign immExt = {{(XLEN-IMM_W){immField[IMM_W-1]}}, immField};

  always_ff @(posedge clk) begin
    if (rst) pc <= XLEN'(RESET_PC);
    else     pc <= pcNext;
  end

  assign pcSeq    = pc + XLEN'(INSTR_B);
  assign pcBranch = pcSeq + {immExt[XLEN-3:0], 2'b00};
  assign pcNext   = (ctrl.branch && aluZero) ? pcBranch : pcSeq;

  assign wrAddr = ctrl.regDstRd ? rdField : rtField;
  assign wbData = ctrl.memToReg ? dataRdata : aluY;

  ucore_regfile #(.XLEN(XLEN), .REG_CNT(REG_CNT)) i_regs (
    .clk     (clk),
    .rdAddrA (rsField),
    .rdAddrB (rtField),
    .rdDataA (rsVal),
    .rdDataB (rtVal),
    .wrEn    (ctrl.regWrite),
    .wrAddr  (wrAddr),
    .wrData  (wbData)
  );

  assign aluB = ctrl.aluSrcImm ? immExt : rtVal;

  ucore_alu #(.XLEN(XLEN)) i_alu (
    .opA    (rsVal),
    .opB    (aluB),
    .op     (ctrl.aluOp),
    .result (aluY),
    .isZero (aluZero)
  );

  assign instrAddr = pc;
  assign dataAddr  = aluY;
  assign dataWdata = rtVal;
  assign dataWe    = ctrl.memWrite;

endmodule

// File: rtl/ucore_top.sv
`timescale 1ns/1ps
module ucore_top
  import ucore_pkg::*;
#(
  parameter int XLEN    = 32,
  parameter int REG_CNT = 32
) (
  input  logic            clk,
  input  logic            rst,
  output logic [XLEN-1:0] instrAddr,
  input  logic [31:0]     instrData,
  output logic [XLEN-1:0] dataAddr,
  output logic [XLEN-1:0] dataWdata,
  output logic            dataWe,
  input  logic [XLEN-1:0] dataRdata
);

  ctrl_t ctrl;

  ucore_control i_ctrl (
    .opcode (instrData[31:26]),
    .funct  (instrData[5:0]),
    .ctrl   (ctrl)
  );

  ucore_datapath #(.XLEN(XLEN), .REG_CNT(REG_CNT)) i_dp (
    .clk       (clk),
    .rst       (rst),
    .ctrl      (ctrl),
    .instrAddr (instrAddr),
    .instrData (instrData),
    .dataAddr  (dataAddr),
    .dataWdata (dataWdata),
    .dataWe    (dataWe),
    .dataRdata (dataRdata)
  );

endmodule

// File: rtl/ucore_checker.sv
`timescale 1ns/1ps
module ucore_checker #(
  parameter int XLEN = 32
) (
  input logic            clk,
  input logic            rst,
  input logic [XLEN-1:0] instrAddr,
  input logic [31:0]     instrData,
  input logic            dataWe
);

  logic rstSeen;
  logic [XLEN-1:0] branchOff;

  always_ff @(posedge clk) rstSeen <= rst;

  assign branchOff = {{(XLEN-18){instrData[15]}}, instrData[15:0], 2'b00};

  // R1: the cycle after a reset edge shows address zero
  always @(negedge clk) begin
    if (rstSeen == 1'b1) begin
      a_r1_reset_pc: assert (instrAddr == '0);
    end
  end

  // R2: non-branch instructions step by one word
  a_r2_seq_step: assert property (@(posedge clk) disable iff (rst)
    (instrData[31:26] != 6'h04) |=> (instrAddr == $past(instrAddr) + XLEN'(4)));

  // R2: the address stays word aligned
  a_r2_aligned: assert property (@(posedge clk) disable iff (rst)
    (instrAddr[1:0] == 2'b00));

  // R8: a branch lands on either the fall-through or the offset target
  a_r8_branch_target: assert property (@(posedge clk) disable iff (rst)
    (instrData[31:26] == 6'h04) |=>
      ((instrAddr == $past(instrAddr) + XLEN'(4)) ||
       (instrAddr == $past(instrAddr) + XLEN'(4) + $past(branchOff))));

  // R7: a store always raises the strobe
  a_r7_store_strobe: assert property (@(posedge clk) disable iff (rst)
    (instrData[31:26] == 6'h2B) |-> dataWe);

  // R10: the strobe appears for nothing but a store
  a_r10_strobe_only_store: assert property (@(posedge clk) disable iff (rst)
    dataWe |-> (instrData[31:26] == 6'h2B));

endmodule

bind ucore_top ucore_checker #(.XLEN(XLEN)) i_chk (.*);

// File: tb/test_ucore_top.sv
`timescale 1ns/1ps
module test_ucore_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] instrData = 32'h0000_0020;
  logic [31:0] instrAddr, dataAddr, dataWdata, dataRdata;
  logic        dataWe;

  always #2.5 clk = ~clk;

  ucore_top i_ucore_top (
    .clk       (clk),
    .rst       (rst),
    .instrAddr (instrAddr),
    .instrData (instrData),
    .dataAddr  (dataAddr),
    .dataWdata (dataWdata),
    .dataWe    (dataWe),
    .dataRdata (dataRdata)
  );

  // environment data memory, 64 words, aliased on address bits 7:2
  logic [31:0] dMem [64];
  assign dataRdata = dMem[dataAddr[7:2]];
  always @(posedge clk) if (dataWe) dMem[dataAddr[7:2]] <= dataWdata;

  // reference model state
  logic [31:0] refRegs [32];
  logic [31:0] refMem  [64];
  logic [31:0] refPc;
  string       regTag  [32];
  string       pcTag;
  int          nChecks = 0;
  int          nFails  = 0;
  bit          done    = 1'b0;

  function automatic logic [31:0] sx(input logic [15:0] v);
    return {{16{v[15]}}, v};
  endfunction

  function automatic logic [31:0] rIns(input int rs, input int rt, input int rd, input logic [5:0] fn);
    return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
  endfunction

  function automatic logic [31:0] iIns(input logic [5:0] op, input int rs, input int rt, input logic [15:0] imm);
    return {op, 5'(rs), 5'(rt), imm};
  endfunction

  function automatic bit knownFn(input logic [5:0] fn);
    return fn == 6'h20 || fn == 6'h22 || fn == 6'h24 || fn == 6'h25 || fn == 6'h2A;
  endfunction

  function automatic string fnTag(input logic [5:0] fn);
    if (fn == 6'h20 || fn == 6'h22) return "R3";
    if (fn == 6'h24 || fn == 6'h25) return "R4";
    return "R5";
  endfunction

  function automatic logic [31:0] aluRef(input logic [5:0] fn, input logic [31:0] a, input logic [31:0] b);
    case (fn)
      6'h20:   return a + b;
      6'h22:   return a - b;
      6'h24:   return a & b;
      6'h25:   return a | b;
      default: return ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // called at a falling edge: drive, check, update model, move to next falling edge
  task automatic apply(input logic [31:0] ins);
    logic [5:0]  op, fn;
    int          rs, rt, rd;
    logic [31:0] rsV, rtV, ea;
    bit          legal;
    op = ins[31:26]; fn = ins[5:0];
    rs = int'(ins[25:21]); rt = int'(ins[20:16]); rd = int'(ins[15:11]);
    rsV = refRegs[rs]; rtV = refRegs[rt];
    ea = rsV + sx(ins[15:0]);
    legal = (op == 6'h00 && knownFn(fn)) || op == 6'h23 || op == 6'h2B || op == 6'h04;
    instrData = ins;
    #1;
    check({pcTag, " pc"}, instrAddr, refPc);
    if (op == 6'h2B) begin
      check("R7 store strobe", {31'd0, dataWe}, 32'd1);
      check("R7 store address", dataAddr, ea);
      check({regTag[rt], " store data"}, dataWdata, rtV);
    end else begin
      check(legal ? "R10 strobe low" : "R11 strobe low", {31'd0, dataWe}, 32'd0);
    end
    if (op == 6'h23) check("R6 load address", dataAddr, ea);
    // commit
    pcTag = legal ? "R2" : "R11";
    refPc = refPc + 32'd4;
    if (op == 6'h00 && knownFn(fn)) begin
      if (rd != 0) begin
        refRegs[rd] = aluRef(fn, rsV, rtV);
        regTag[rd]  = fnTag(fn);
      end
    end else if (op == 6'h23) begin
      if (rt != 0) begin
        refRegs[rt] = refMem[ea[7:2]];
        regTag[rt]  = "R6";
      end
    end else if (op == 6'h2B) begin
      refMem[ea[7:2]] = rtV;
    end else if (op == 6'h04) begin
      pcTag = "R8";
      if (rsV == rtV) refPc = refPc + {sx(ins[15:0])[29:0], 2'b00};
    end
    @(negedge clk);
  endtask

  task automatic randomIns();
    int k;
    int a, b, c;
    logic [5:0] fns [5];
    fns[0] = 6'h20; fns[1] = 6'h22; fns[2] = 6'h24; fns[3] = 6'h25; fns[4] = 6'h2A;
    k = int'($urandom_range(99));
    a = int'($urandom_range(31)); b = int'($urandom_range(31)); c = int'($urandom_range(31));
    if (k < 48)      apply(rIns(a, b, c, fns[$urandom_range(4)]));
    else if (k < 52) apply(rIns(a, b, c, 6'(6'h30 + 6'($urandom_range(7)))));
    else if (k < 67) apply(iIns(6'h23, a, b, 16'($urandom)));
    else if (k < 87) apply(iIns(6'h2B, a, b, 16'($urandom)));
    else if (k < 96) apply(iIns(6'h04, a, ($urandom_range(3) == 0) ? a : b, 16'(int'($urandom_range(64)) - 32)));
    else             apply(iIns(6'h08, a, b, 16'($urandom)));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nFails++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20061));
    for (int i = 0; i < 64; i++) begin
      dMem[i] = $urandom;
    end
    dMem[1] = 32'h8000_0000; dMem[2] = 32'h7FFF_FFFF;
    dMem[3] = 32'hFFFF_FFFF; dMem[4] = 32'h0000_0000;
    for (int i = 0; i < 64; i++) refMem[i] = dMem[i];
    for (int i = 0; i < 32; i++) begin
      refRegs[i] = 32'h0;
      regTag[i]  = "R9";
    end

    // R1: reset state
    repeat (3) @(negedge clk);
    check("R1 reset pc", instrAddr, 32'h0);
    rst = 1'b0;
    refPc = 32'h0;
    pcTag = "R1";

    // fill registers 1..31 from memory words 1..31 (R6)
    for (int r = 1; r < 32; r++) apply(iIns(6'h23, 0, r, 16'(4 * r)));

    // R5 signed compare corners
    apply(rIns(1, 2, 5, 6'h2A)); apply(iIns(6'h2B, 0, 5, 16'h0100));
    apply(rIns(2, 1, 6, 6'h2A)); apply(iIns(6'h2B, 0, 6, 16'h0104));
    apply(rIns(3, 4, 7, 6'h2A)); apply(iIns(6'h2B, 0, 7, 16'h0108));
    apply(rIns(4, 4, 7, 6'h2A)); apply(iIns(6'h2B, 0, 7, 16'h0108));
    // R3 wraparound, R4 logic ops
    apply(rIns(2, 2, 8, 6'h20));  apply(iIns(6'h2B, 0, 8, 16'h0010));
    apply(rIns(4, 1, 9, 6'h22));  apply(iIns(6'h2B, 0, 9, 16'h0014));
    apply(rIns(1, 3, 10, 6'h24)); apply(iIns(6'h2B, 0, 10, 16'h0018));
    apply(rIns(1, 2, 11, 6'h25)); apply(iIns(6'h2B, 0, 11, 16'h001C));
    // same register read and written in one cycle
    apply(rIns(3, 3, 3, 6'h20));  apply(iIns(6'h2B, 0, 3, 16'h0020));
    // R9: write to register 0 is dropped
    apply(rIns(2, 2, 0, 6'h20));  apply(iIns(6'h2B, 0, 0, 16'h0024));
    apply(iIns(6'h23, 0, 0, 16'h0004)); apply(iIns(6'h2B, 0, 0, 16'h0028));
    // store then immediate load of the same word, negative offset
    apply(iIns(6'h2B, 12, 2, 16'hFFF0)); apply(iIns(6'h23, 12, 13, 16'hFFF0));
    apply(iIns(6'h2B, 0, 13, 16'h002C));
    // R8: taken backward, not taken
    apply(iIns(6'h04, 0, 0, 16'hFFFD));
    apply(iIns(6'h04, 1, 2, 16'h0040));
    apply(iIns(6'h04, 0, 4, 16'h7FFF));
    // R11: unknown opcode and unknown function code
    apply(iIns(6'h08, 0, 14, 16'h0055)); apply(iIns(6'h2B, 0, 14, 16'h0030));
    apply(rIns(2, 2, 15, 6'h21));        apply(iIns(6'h2B, 0, 15, 16'h0034));

    for (int n = 0; n < 4000; n++) randomIns();

    // R1: reset in mid-run, registers keep their values
    rst = 1'b1;
    instrData = 32'h0000_0020;
    @(negedge clk);
    check("R1 mid-run reset pc", instrAddr, 32'h0);
    rst = 1'b0;
    refPc = 32'h0;
    pcTag = "R1";
    for (int n = 0; n < 600; n++) randomIns();
    for (int r = 0; r < 32; r++) apply(iIns(6'h2B, 0, r, 16'(4 * r)));

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule